// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides which interrupt a small CPU core enters next. Each maskable source raises a request that is held in a pending latch. A source is eligible when its enable is set and its 2-bit software level is strictly above the running level. When several sources are eligible, the highest software level wins. Within that level, the fixed hardware rank decides, and a lower source index ranks higher. Three non-maskable inputs also take part: a reset request, a software trap strobe and a top-level hardware interrupt. They behave as level 3, they ignore enables and the running level, and they rank above every maskable source in the order reset, top-level interrupt, trap.

On a grant, the block pulses a take strobe for one cycle, presents the vector index and the level the core will run at, and clears the pending latch of the granted source. On the next clock edge it pushes the previous running level onto a small stack. A restore input pops that level back on return from the handler. A trap is held off while the top-level interrupt is in service. A reset grant empties the stack. A wake output tells a halt controller that something worth waking for is pending.

Top module: `irq_arbiter`

## Requirements
- R1: After rst_ni, nothing is pending, take_o is 0, wake_o is 0 and the running level lvl_o is 3.
- R2: A maskable request is latched. It is granted only while its enable is 1 and its level (prio_i bits [2i+1:2i]) is strictly greater than lvl_o. Otherwise it stays pending until it becomes eligible.
- R3: Among eligible maskable sources, the highest level wins, and a tie goes to the lowest index.
- R4: Pending non-maskable requests are granted whatever the enables and the running level are. The order is reset, then top-level interrupt, then trap, and all three rank above every maskable source. Their grant level is 3.
- R5: Vector encoding: maskable source i gives i, trap gives N_SRC, top-level interrupt gives N_SRC+1 and reset gives N_SRC+2. take_lvl_o shows the granted level, and lvl_o takes that value from the next cycle on.
- R6: take_o is a single-cycle pulse per grant, and the grant clears that source's pending latch. A new request in the same cycle is kept.
- R7: A clear strobe discards a pending maskable request that was never served. If the request and the clear arrive in the same cycle, the clear wins.
- R8: restore_i pops the previous running level. On an empty stack it sets level 0. No grant is made in a cycle with restore_i high.
- R9: While the top-level interrupt is in service, a trap stays pending and is not granted. The top-level interrupt may preempt a trap in service.
- R10: A reset grant empties the level stack and sets the running level to 3.
- R11: wake_o is 1 while any non-maskable request is pending, or while a maskable source selected by WAKE_MASK is pending. Enables have no effect on it.
- R12: A push onto a full stack discards the oldest saved level. Later pops return the remaining levels newest first and then level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Maskable request strobes |
| clr_i | input | N_SRC | Pending-clear strobes |
| en_i | input | N_SRC | Per-source enables |
| prio_i | input | 2*N_SRC | Per-source software levels, 2 bits each |
| trap_i | input | 1 | Software trap strobe |
| tli_i | input | 1 | Top-level hardware interrupt strobe |
| rst_req_i | input | 1 | Reset source request |
| restore_i | input | 1 | Return from interrupt: pop level |
| take_o | output | 1 | Grant strobe |
| vec_o | output | VEC_W | Granted vector index |
| take_lvl_o | output | 2 | Level entered on grant |
| lvl_o | output | 2 | Current running level |
| wake_o | output | 1 | Wake request for halt control |

## Verification
On every cycle, the assertions check the following local rules:
- restore blocks a grant;
- a maskable grant lies strictly above the running level;
- a non-maskable grant enters level 3;
- the running level follows the grant one cycle later;
- a trap is never granted inside the top-level handler;
- any non-maskable strobe raises wake in the next cycle.

Only the bench's scenarios can show the choices that depend on history. These are which source wins a level tie, that a cleared request is really lost, the order in which nested levels come back through restore, the discard of the oldest frame when the stack overflows, and the emptying of the stack by a reset grant.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'd3;

  typedef struct packed {
    logic tli;
    lvl_t lvl;
  } frame_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // new request beats grant-clear, explicit clear beats both
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= ((pend_q[i] & ~take_i[i]) | set_i[i]) & ~clr_i[i];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 8,
  parameter int LW    = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    elig_i,
  input  logic [N*LW-1:0] lvls_i,
  output logic            valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LW-1:0]   lvl_o
);
  // index 0 has the highest hardware rank; strict compare keeps it on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!valid_o || (lvls_i[i*LW +: LW] > lvl_o))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvls_i[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic flush_i,
  input  lvl_t take_lvl_i,
  input  logic take_tli_i,
  input  logic pop_i,
  output lvl_t lvl_o,
  output logic tli_o
);
  localparam int CW = $clog2(DEPTH + 1);

  frame_t        cur_q;
  frame_t        stk_q [DEPTH];
  logic [CW-1:0] cnt_q;

  logic push, pop;
  assign push = take_i & ~flush_i;
  assign pop  = pop_i & ~take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{tli: 1'b0, lvl: LVL_TOP};
      cnt_q <= '0;
    end else if (take_i) begin
      if (flush_i) begin
        cur_q <= '{tli: 1'b0, lvl: LVL_TOP};
        cnt_q <= '0;
      end else begin
        cur_q <= '{tli: take_tli_i, lvl: take_lvl_i};
        if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
      end
    end else if (pop) begin
      if (cnt_q != '0) begin
        cur_q <= stk_q[0];
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cur_q <= '0;
      end
    end
  end

  // entry 0 is the top; a push into a full stack drops the last entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    frame_t up_val, dn_val;
    if (k == 0) begin : g_top
      assign dn_val = cur_q;
    end else begin : g_mid
      assign dn_val = stk_q[k-1];
    end
    if (k == DEPTH - 1) begin : g_bot
      assign up_val = '0;
    end else begin : g_nbot
      assign up_val = stk_q[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stk_q[k] <= '0;
      else if (push) stk_q[k] <= dn_val;
      else if (pop)  stk_q[k] <= up_val;
    end
  end

  assign lvl_o = cur_q.lvl;
  assign tli_o = cur_q.tli;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int               N_SRC     = 8,
  parameter int               STK_DEPTH = 4,
  parameter logic [N_SRC-1:0] WAKE_MASK = '1,
  localparam int              VEC_W     = $clog2(N_SRC + 3),
  localparam int              IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [N_SRC-1:0]   clr_i,
  input  logic [N_SRC-1:0]   en_i,
  input  logic [2*N_SRC-1:0] prio_i,
  input  logic               trap_i,
  input  logic               tli_i,
  input  logic               rst_req_i,
  input  logic               restore_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [1:0]         take_lvl_o,
  output logic [1:0]         lvl_o,
  output logic               wake_o
);
  localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(N_SRC);
  localparam logic [VEC_W-1:0] V_TLI  = VEC_W'(N_SRC + 1);
  localparam logic [VEC_W-1:0] V_RST  = VEC_W'(N_SRC + 2);

  localparam int NM_TRAP = 0;
  localparam int NM_TLI  = 1;
  localparam int NM_RST  = 2;

  logic [N_SRC-1:0] pend, elig, m_take;
  logic [2:0]       nm_pend, nm_set, nm_take;
  logic             m_valid;
  logic [IDX_W-1:0] m_idx;
  lvl_t             m_lvl;
  lvl_t             run_lvl;
  logic             tli_act;
  logic             sel_rst, sel_tli, sel_trap, sel_nm, grant;

  irq_pend_bank #(.N(N_SRC)) u_mpend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr_i),
    .take_i (m_take),
    .pend_o (pend)
  );

  assign nm_set = {rst_req_i, tli_i, trap_i};

  irq_pend_bank #(.N(3)) u_npend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (nm_set),
    .clr_i  (3'b000),
    .take_i (nm_take),
    .pend_o (nm_pend)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i]   = pend[i] & en_i[i] & (prio_i[2*i +: 2] > run_lvl);
    assign m_take[i] = grant & ~sel_nm & (m_idx == IDX_W'(i));
  end

  irq_pick #(.N(N_SRC), .LW(2)) u_pick (
    .elig_i  (elig),
    .lvls_i  (prio_i),
    .valid_o (m_valid),
    .idx_o   (m_idx),
    .lvl_o   (m_lvl)
  );

  // fixed order among the level-3 sources: reset, top-level, trap
  assign sel_rst  = nm_pend[NM_RST];
  assign sel_tli  = ~sel_rst & nm_pend[NM_TLI];
  assign sel_trap = ~sel_rst & ~nm_pend[NM_TLI] & nm_pend[NM_TRAP] & ~tli_act;
  assign sel_nm   = sel_rst | sel_tli | sel_trap;
  assign grant    = ~restore_i & (sel_nm | m_valid);

  assign nm_take = {grant & sel_rst, grant & sel_tli, grant & sel_trap};

  always_comb begin
    if (sel_rst)       vec_o = V_RST;
    else if (sel_tli)  vec_o = V_TLI;
    else if (sel_trap) vec_o = V_TRAP;
    else               vec_o = VEC_W'(m_idx);
  end

  assign take_o     = grant;
  assign take_lvl_o = sel_nm ? LVL_TOP : m_lvl;

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (grant),
    .flush_i    (sel_rst),
    .take_lvl_i (take_lvl_o),
    .take_tli_i (sel_tli),
    .pop_i      (restore_i),
    .lvl_o      (run_lvl),
    .tli_o      (tli_act)
  );

  assign lvl_o  = run_lvl;
  assign wake_o = (|(pend & WAKE_MASK)) | (|nm_pend);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trap_i,
  input logic             tli_i,
  input logic             rst_req_i,
  input logic             restore_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [1:0]       take_lvl_o,
  input logic [1:0]       lvl_o,
  input logic             wake_o,
  input logic             tli_act_i
);
  localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(N_SRC);

  a_r8_restore_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |-> !take_o);

  a_r2_above_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o < V_TRAP) |-> (take_lvl_o > lvl_o));

  a_r4_nmi_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o >= V_TRAP) |-> (take_lvl_o == 2'd3));

  a_r5_level_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (lvl_o == $past(take_lvl_o)));

  a_r9_trap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == V_TRAP) |-> !tli_act_i);

  a_r11_wake_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i || tli_i || rst_req_i) |=> wake_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_i     (trap_i),
  .tli_i      (tli_i),
  .rst_req_i  (rst_req_i),
  .restore_i  (restore_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .take_lvl_o (take_lvl_o),
  .lvl_o      (lvl_o),
  .wake_o     (wake_o),
  .tli_act_i  (tli_act)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, clr = '0, en = '0;
  logic [15:0] prio = 16'h2DA7; // levels src7..src0: 0,2,3,1,2,2,1,3
  logic       trap = 1'b0, tli = 1'b0, rstq = 1'b0, rsto = 1'b0;
  logic       take, wake;
  logic [3:0] vec;
  logic [1:0] take_lvl, lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter #(.N_SRC(8), .STK_DEPTH(4), .WAKE_MASK(8'h0F)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clr_i(clr), .en_i(en),
    .prio_i(prio), .trap_i(trap), .tli_i(tli), .rst_req_i(rstq),
    .restore_i(rsto), .take_o(take), .vec_o(vec), .take_lvl_o(take_lvl),
    .lvl_o(lvl), .wake_o(wake)
  );

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] req;
    logic [7:0] clr;
    logic [2:0] nmi;   // {reset, top-level, trap}
    logic       rsto;
    logic       etake;
    logic [3:0] evec;
    logic [1:0] elvl;
    logic [7:0] rq;
  } row_t;

  localparam row_t MAIN [23] = '{
    '{8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd0, 8'd8 },  // R8 empty pop -> 0
    '{8'h00, 8'h04, 8'h00, 3'd0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd2 },  // R2 disabled stays pending
    '{8'h04, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 4'd2,  2'd2, 8'd6 },  // R6 enable -> one take
    '{8'h26, 8'h22, 8'h00, 3'd0, 1'b0, 1'b1, 4'd5,  2'd3, 8'd2 },  // R2 only level above 2
    '{8'h26, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd2, 8'd8 },  // R8 pop 2
    '{8'h26, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 4'd1,  2'd1, 8'd8 },  // R8 pop 0, src1 served
    '{8'h26, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd0, 8'd8 },
    '{8'hFF, 8'h58, 8'h00, 3'd0, 1'b0, 1'b1, 4'd3,  2'd2, 8'd3 },  // R3 tie -> lower index
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 4'd6,  2'd2, 8'd3 },  // R3 level beats index
    '{8'hFF, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 4'd8,  2'd3, 8'd4 },  // R4 trap
    '{8'hFF, 8'h00, 8'h00, 3'd2, 1'b0, 1'b1, 4'd9,  2'd3, 8'd9 },  // R9 top-level preempts trap
    '{8'hFF, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 4'd0,  2'd3, 8'd9 },  // R9 trap held
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 4'd8,  2'd3, 8'd9 },  // R9 trap after return
    '{8'hFF, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0, 4'd0,  2'd3, 8'd2 },  // R2 equal level not served
    '{8'hFF, 8'h00, 8'h01, 3'd0, 1'b0, 1'b0, 4'd0,  2'd3, 8'd7 },  // R7 clear pending
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd3, 8'd8 },
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd2, 8'd8 },
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 4'd4,  2'd1, 8'd7 },  // R7 src0 was lost
    '{8'hFF, 8'h20, 8'h00, 3'd4, 1'b0, 1'b1, 4'd10, 2'd3, 8'd10 }, // R10 reset grant
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b1, 4'd5,  2'd3, 8'd10 }, // R10 stack emptied
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0,  2'd0, 8'd8 },
    '{8'hFF, 8'h80, 8'h00, 3'd0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd2 },  // R2 level 0 never served
    '{8'hFF, 8'h01, 8'h01, 3'd0, 1'b0, 1'b0, 4'd0,  2'd0, 8'd7 }   // R7 clear beats request
  };

  localparam row_t OVFL [11] = '{
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd0, 8'd8 },
    '{8'hFF, 8'h10, 8'h00, 3'd0, 1'b0, 1'b1, 4'd4, 2'd1, 8'd5 },   // R5
    '{8'hFF, 8'h04, 8'h00, 3'd0, 1'b0, 1'b1, 4'd2, 2'd2, 8'd5 },
    '{8'hFF, 8'h01, 8'h00, 3'd0, 1'b0, 1'b1, 4'd0, 2'd3, 8'd5 },
    '{8'hFF, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 4'd8, 2'd3, 8'd4 },
    '{8'hFF, 8'h00, 8'h00, 3'd2, 1'b0, 1'b1, 4'd9, 2'd3, 8'd4 },   // full push
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd3, 8'd12 },  // R12
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd3, 8'd12 },
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd2, 8'd12 },
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd1, 8'd12 },
    '{8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0, 4'd0, 2'd0, 8'd12 }   // oldest 0 was dropped
  };

  task automatic chk(input int rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; clr = '0; en = '0; trap = 0; tli = 0; rstq = 0; rsto = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a falling edge; two cycles, takes counted in both
  task automatic run_row(input row_t r);
    int ntk = 0;
    int v = -1;
    int tl = -1;
    en = r.en; req = r.req; clr = r.clr; {rstq, tli, trap} = r.nmi; rsto = r.rsto;
    #1;
    if (take) begin ntk++; v = vec; tl = take_lvl; end
    @(posedge clk); @(negedge clk);
    req = '0; clr = '0; {rstq, tli, trap} = 3'b000; rsto = 1'b0;
    #1;
    if (take) begin ntk++; if (v < 0) begin v = vec; tl = take_lvl; end end
    @(posedge clk); @(negedge clk);
    chk(r.rq, "take count", ntk, r.etake);
    if (r.etake) begin
      chk(r.rq, "vector", v, r.evec);
      chk(r.rq, "take level", tl, r.elvl);
    end
    chk(r.rq, "running level", lvl, r.elvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk(1, "reset take", take, 0);   // R1
    chk(1, "reset level", lvl, 3);
    chk(1, "reset wake", wake, 0);

    // R11: wake follows masked pending set, independent of enables
    @(negedge clk); req = 8'h80;
    @(negedge clk); req = '0; #1;
    chk(11, "wake unmasked src", wake, 0);
    @(negedge clk); req = 8'h02;
    @(negedge clk); req = '0; #1;
    chk(11, "wake masked src", wake, 1);
    @(negedge clk); clr = 8'h02;
    @(negedge clk); clr = '0; #1;
    chk(11, "wake after clear", wake, 0);
    @(negedge clk); trap = 1'b1;
    @(negedge clk); trap = 1'b0; #1;
    chk(11, "wake trap", wake, 1);
    chk(4, "trap at level 3 take", take, 1);   // R4
    chk(4, "trap vector", vec, 8);
    @(negedge clk);

    do_reset();
    foreach (MAIN[i]) run_row(MAIN[i]);

    // R4 order among simultaneous non-maskables, R9 trap hold
    do_reset();
    @(negedge clk); rsto = 1'b1;
    @(negedge clk); rsto = 1'b0; {rstq, tli, trap} = 3'b111;
    @(negedge clk); {rstq, tli, trap} = 3'b000; #1;
    chk(4, "first nmi", vec, 10);
    chk(4, "first nmi take", take, 1);
    @(negedge clk); #1;
    chk(4, "second nmi", vec, 9);
    chk(4, "second nmi take", take, 1);
    @(negedge clk); #1;
    chk(9, "trap held in top-level", take, 0);
    chk(9, "trap still pending", wake, 1);
    chk(10, "level after nmis", lvl, 3);
    @(negedge clk); rsto = 1'b1; #1;
    chk(8, "restore blocks grant", take, 0);
    @(negedge clk); rsto = 1'b0; #1;
    chk(9, "trap after return take", take, 1);
    chk(9, "trap after return vec", vec, 8);
    @(negedge clk);

    do_reset();
    foreach (OVFL[i]) run_row(OVFL[i]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule